// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the opening Start condition of an I2C transfer on behalf of a bus master. A software request strobe starts a two-phase sequence paced by a reloadable baud-period down-counter. In the first period, both bus lines must stay released and high. When that period expires, the block pulls SDA low while SCL is left alone, which forms the Start condition. In the second period, SDA is held low. When the second period ends, the sequence is complete and SDA is left held low for the data stage that follows.

The block watches both lines from the moment of the request until SDA is pulled down. If either line is found low in that window, another device owns the bus. The block then raises a sticky collision flag and falls back to idle without driving anything. Completion raises a sticky interrupt flag. A clear strobe drops both flags, and it also releases a held SDA, which returns the block to idle.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, no line is driven, the busy, start-seen, interrupt and collision outputs are all 0.
- R2: A request accepted with both lines high sets busy on the next clock edge and loads the counter with the reload value; busy stays high until completion or abort.
- R3: SDA drive (1 = pull low) asserts exactly reload+1 clock edges after busy rises, start-seen rises in the same cycle, and SCL drive is never asserted.
- R4: Exactly reload+1 edges after SDA drive asserts, busy drops, the interrupt flag sets and SDA drive stays asserted.
- R5: A request sampled with SDA or SCL low sets the collision flag on the next edge, leaves busy low and drives no line.
- R6: SDA or SCL sampled low in any cycle of the first period, including its last, aborts: busy drops, the collision flag sets, SDA is never driven.
- R7: A low line during the second period has no effect on timing or flags.
- R8: A request while busy or while SDA is held is ignored.
- R9: Interrupt and collision flags stay set until the clear strobe; the clear strobe in the held state releases SDA, clears start-seen and returns to idle.
- R10: When a flag is set and cleared in the same cycle, the set wins.
- R11: A reload value of 0 gives one-cycle periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reloadVal | input | CNT_W | Baud period reload value, period = value+1 cycles |
| startReq | input | 1 | Start request strobe |
| flagClr | input | 1 | Clears interrupt and collision flags, releases held SDA |
| sdaIn | input | 1 | Sampled SDA line level |
| sclIn | input | 1 | Sampled SCL line level |
| sdaDrive | output | 1 | SDA pull-low enable |
| sclDrive | output | 1 | SCL pull-low enable |
| startBusy | output | 1 | Start sequence in progress |
| startSeen | output | 1 | Start condition placed on the bus |
| doneIrq | output | 1 | Sticky completion flag |
| busColl | output | 1 | Sticky bus collision flag |

## Verification
Two events can land on the same edge: the clear strobe, and the setting of a flag, either through a collision found in the first period or through completion at the end of the second. The bench times the clear strobe onto the exact cycle in which the line drop, or the counter expiry, is sampled. The flag must then read 1 afterwards. A per-cycle behavioural model, in which setting is applied after clearing, judges every other cycle.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2,
    ST_HELD = 2'd3
  } startState_t;

  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/i2c_start_dp.sv
module i2c_start_dp
  import i2c_start_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] reloadVal,
  input  cntStrobe_t       strobes,
  output logic             cntZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.load) begin
      cnt <= reloadVal;
    end else if (strobes.dec) begin
      cnt <= cnt - ONE;
    end
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_start_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       flagClr,
  input  logic       sdaIn,
  input  logic       sclIn,
  input  logic       cntZero,
  output cntStrobe_t strobes,
  output logic       sdaDrive,
  output logic       startBusy,
  output logic       startSeen,
  output logic       doneIrq,
  output logic       busColl
);
  startState_t st, nxt;
  logic setColl, setIrq, busHigh;

  assign busHigh = sdaIn && sclIn;

  always_comb begin
    nxt = st;
    strobes = '0;
    setColl = 1'b0;
    setIrq = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (startReq) begin
          if (busHigh) begin
            nxt = ST_WAIT;
            strobes.load = 1'b1;
          end else begin
            setColl = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!busHigh) begin
          nxt = ST_IDLE;
          setColl = 1'b1;
        end else if (cntZero) begin
          nxt = ST_HOLD;
          strobes.load = 1'b1;
        end else begin
          strobes.dec = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          nxt = ST_HELD;
          setIrq = 1'b1;
        end else begin
          strobes.dec = 1'b1;
        end
      end
      ST_HELD: begin
        if (flagClr) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      startSeen <= 1'b0;
      doneIrq <= 1'b0;
      busColl <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_WAIT && nxt == ST_HOLD) startSeen <= 1'b1;
      else if (nxt == ST_IDLE) startSeen <= 1'b0;
      if (setIrq) doneIrq <= 1'b1;
      else if (flagClr) doneIrq <= 1'b0;
      if (setColl) busColl <= 1'b1;
      else if (flagClr) busColl <= 1'b0;
    end
  end

  assign sdaDrive = (st == ST_HOLD) || (st == ST_HELD);
  assign startBusy = (st == ST_WAIT) || (st == ST_HOLD);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             startReq,
  input  logic             flagClr,
  input  logic             sdaIn,
  input  logic             sclIn,
  output logic             sdaDrive,
  output logic             sclDrive,
  output logic             startBusy,
  output logic             startSeen,
  output logic             doneIrq,
  output logic             busColl
);
  cntStrobe_t strobes;
  logic cntZero;

  i2c_start_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .flagClr(flagClr),
    .sdaIn(sdaIn), .sclIn(sclIn), .cntZero(cntZero), .strobes(strobes),
    .sdaDrive(sdaDrive), .startBusy(startBusy), .startSeen(startSeen),
    .doneIrq(doneIrq), .busColl(busColl)
  );

  i2c_start_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .reloadVal(reloadVal), .strobes(strobes),
    .cntZero(cntZero)
  );

  assign sclDrive = 1'b0;
endmodule

// File: rtl/i2c_start_chk.sv
module i2c_start_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic flagClr,
  input logic sdaIn,
  input logic sclIn,
  input logic sdaDrive,
  input logic sclDrive,
  input logic startBusy,
  input logic startSeen,
  input logic doneIrq,
  input logic busColl
);
  // R6
  collision_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startBusy && !sdaDrive && (!sdaIn || !sclIn)) |=> (!startBusy && busColl && !sdaDrive));

  // R5
  req_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startBusy && !sdaDrive && startReq && (!sdaIn || !sclIn)) |=> (busColl && !startBusy && !sdaDrive));

  // R4
  sda_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrive && !flagClr) |=> sdaDrive);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && !flagClr) |=> doneIrq);

  // R3
  seen_with_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrive) |-> (startSeen && !sclDrive));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && startBusy && !sdaDrive && !sdaIn) |=> busColl);
endmodule

bind i2c_start_gen i2c_start_chk u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .flagClr(flagClr),
  .sdaIn(sdaIn), .sclIn(sclIn), .sdaDrive(sdaDrive), .sclDrive(sclDrive),
  .startBusy(startBusy), .startSeen(startSeen), .doneIrq(doneIrq),
  .busColl(busColl)
);

// File: tb/i2c_start_gen_bench.sv
`timescale 1ns/1ps
module i2c_start_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] reloadVal = 8'd3;
  logic startReq = 1'b0, flagClr = 1'b0;
  logic sdaPull = 1'b0, sclPull = 1'b0;
  logic sdaIn, sclIn;
  logic sdaDrive, sclDrive, startBusy, startSeen, doneIrq, busColl;
  int errors = 0, checks = 0, cycles = 0;

  // model state: 0 idle, 1 first period, 2 second period, 3 held
  int mPhase = 0, mRem = 0;
  bit mSeen = 0, mIrq = 0, mColl = 0;

  always #2 clk = ~clk;

  assign sdaIn = !(sdaPull || sdaDrive);
  assign sclIn = !(sclPull || sclDrive);

  i2c_start_gen u_i2c_start_gen (
    .clk(clk), .rstN(rstN), .reloadVal(reloadVal), .startReq(startReq),
    .flagClr(flagClr), .sdaIn(sdaIn), .sclIn(sclIn), .sdaDrive(sdaDrive),
    .sclDrive(sclDrive), .startBusy(startBusy), .startSeen(startSeen),
    .doneIrq(doneIrq), .busColl(busColl)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rstN) begin
      bit released;
      released = 0;
      if (flagClr) begin
        mIrq = 0;
        mColl = 0;
        if (mPhase == 3) begin
          mPhase = 0;
          mSeen = 0;
          released = 1;
        end
      end
      if (!released) begin
        if (mPhase == 0) begin
          if (startReq) begin
            if (sdaIn && sclIn) begin mPhase = 1; mRem = reloadVal; end
            else mColl = 1;
          end
        end else if (mPhase == 1) begin
          if (!sdaIn || !sclIn) begin mColl = 1; mPhase = 0; end
          else if (mRem == 0) begin mPhase = 2; mRem = reloadVal; mSeen = 1; end
          else mRem--;
        end else if (mPhase == 2) begin
          if (mRem == 0) begin mPhase = 3; mIrq = 1; end
          else mRem--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R3 sdaDrive model", sdaDrive, (mPhase >= 2) ? 1 : 0);
      chk("R3 sclDrive model", sclDrive, 0);
      chk("R2 startBusy model", startBusy, (mPhase == 1 || mPhase == 2) ? 1 : 0);
      chk("R3 startSeen model", startSeen, mSeen);
      chk("R4 doneIrq model", doneIrq, mIrq);
      chk("R6 busColl model", busColl, mColl);
    end
    if (cycles > 20000) begin
      chk("watchdog", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic pulseReq();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic pulseClr();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  // returns negedges counted after the request until sdaDrive, then until irq
  task automatic runStart(int r, string tag, bit reqMid, bit sclLowHold);
    int n;
    n = 0;
    reloadVal = 8'(r);
    startReq = 1'b1;
    do begin
      @(negedge clk);
      startReq = (reqMid && n == 0) ? 1'b1 : 1'b0;
      n++;
    end while (!sdaDrive && n < 600);
    startReq = 1'b0;
    chk({tag, " R3 edges to SDA drive"}, n, r + 2);
    chk({tag, " R3 startSeen with drive"}, startSeen, 1);
    n = 0;
    sclPull = sclLowHold;
    do begin
      @(negedge clk);
      if (reqMid) startReq = 1'b1;
      n++;
    end while (!doneIrq && n < 600);
    startReq = 1'b0;
    sclPull = 1'b0;
    chk({tag, " R4 edges to done"}, n, r + 1);
    chk({tag, " R4 busy dropped"}, startBusy, 0);
    chk({tag, " R4 SDA still held"}, sdaDrive, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sdaDrive", sdaDrive, 0);
    chk("R1 reset busy", startBusy, 0);
    chk("R1 reset flags", {startSeen, doneIrq, busColl}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runStart(3, "base", 0, 0);
    repeat (4) @(negedge clk);
    chk("R9 irq sticky", doneIrq, 1);
    chk("R4 SDA held while idle wait", sdaDrive, 1);
    pulseReq();
    chk("R8 request while held ignored", {startBusy, busColl}, 0);
    pulseClr();
    chk("R9 clear releases SDA", sdaDrive, 0);
    chk("R9 clear drops irq", doneIrq, 0);
    chk("R9 clear drops startSeen", startSeen, 0);

    runStart(5, "mid-request", 1, 0);
    pulseClr();
    runStart(4, "scl-low-hold R7", 0, 1);
    chk("R7 no collision in second period", busColl, 0);
    pulseClr();
    runStart(0, "zero R11", 0, 0);
    pulseClr();

    sdaPull = 1'b1;
    pulseReq();
    sdaPull = 1'b0;
    chk("R5 SDA low at request", busColl, 1);
    chk("R5 stays idle", startBusy, 0);
    repeat (3) @(negedge clk);
    chk("R9 collision sticky", busColl, 1);
    pulseClr();
    sclPull = 1'b1;
    pulseReq();
    sclPull = 1'b0;
    chk("R5 SCL low at request", busColl, 1);
    pulseClr();

    reloadVal = 8'd4;
    pulseReq();
    @(negedge clk);
    sclPull = 1'b1;
    @(negedge clk);
    sclPull = 1'b0;
    chk("R6 SCL low mid period abort", {startBusy, busColl, sdaDrive}, 3'b010);
    pulseClr();

    reloadVal = 8'd2;
    pulseReq();
    repeat (2) @(negedge clk);
    sdaPull = 1'b1;
    flagClr = 1'b1;
    @(negedge clk);
    sdaPull = 1'b0;
    flagClr = 1'b0;
    chk("R6 SDA low last cycle abort", {startBusy, sdaDrive}, 0);
    chk("R10 collision set beats clear", busColl, 1);
    pulseClr();

    reloadVal = 8'd1;
    pulseReq();
    repeat (2) @(negedge clk);
    chk("R3 drive after reload 1", sdaDrive, 1);
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    chk("R10 irq set beats clear", doneIrq, 1);
    chk("R10 SDA still held", sdaDrive, 1);
    pulseClr();
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule